// File: doc/BRIEF.md
# Dual-direction ring interconnect stop array

This block is a parameterized ring of stops that moves short messages between the agents of a multi-core cluster: core agents, last-level-cache slices and one system agent. Two unidirectional rings run side by side. Request messages (read and snoop) travel towards increasing stop numbers. Response messages (data and writeback) travel towards decreasing stop numbers. Every hop between neighbouring stops is one register, so a message takes exactly one cycle per hop. The system agent is stop 0. It is an ordinary stop, and traffic whose path crosses it is forwarded like any other traffic.

Each stop has one local injection port and one local delivery port. An injected message goes into the stop's outgoing slot on the ring that its kind selects. A message that is already on the ring always wins the slot, so a local injection waits for an empty slot. For a read request the stop replaces the given destination with a slice stop. It finds that slice by XOR-folding the line address, so lines are spread evenly over all slices.

At the destination, a two-state delivery machine holds the message until the local consumer accepts it. The states are EJ_IDLE and EJ_HOLD. The transitions are: capture (EJ_IDLE to EJ_HOLD), drain (EJ_HOLD to EJ_IDLE on ready with nothing new), drain-and-capture (EJ_HOLD to EJ_HOLD) and stall (EJ_HOLD kept while ready is low). A message that arrives for a busy stop is not dropped. It stays on the ring and comes round again. When both rings bring a message for the same stop in the same cycle, the response is taken first.

Top module: `ring_fabric`

## Requirements
- R1: After reset every delivery output is invalid and every injection port reports ready.
- R2: Kinds 0 (read request) and 1 (snoop request) travel from stop i to stop (i+1) mod N. Kinds 2 (data response) and 3 (writeback data) travel from stop i to stop (i-1) mod N. On an idle ring the first cycle of out_valid at the destination comes exactly d rising edges after the injection handshake edge, where d is the hop count in that ring's direction.
- R3: A message whose destination equals its source circles the whole ring and is delivered after N edges.
- R4: For kind 0 the destination is SLICE_FIRST + s, and the given inj_dst is ignored. Here s is the XOR of all address bits b ≥ LINE_OFF folded onto bit position (b-LINE_OFF) mod log2(NUM_SLICES), taken mod NUM_SLICES.
- R5: A stop's inj_ready for a kind is low while that kind's ring brings into the stop a message that the stop does not deliver. Traffic already on the ring is never delayed by injection, and an injection blocked this way proceeds in the first free cycle.
- R6: While out_valid is high and out_ready is low, the delivered source, kind and data stay stable. A message arriving for a stop that cannot accept it stays on the ring and arrives again N edges later.
- R7: When both rings offer a message to the same stop in the same cycle, the response is delivered and the request continues round the ring.
- R8: The delivered out_src, out_kind and out_data equal the injecting stop's number, the injected kind and the injected data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | NUM_STOPS | Per-stop injection request |
| inj_ready | output | NUM_STOPS | Per-stop injection accepted this cycle |
| inj_kind | input | NUM_STOPS x 2 | Message kind: 0 read, 1 snoop, 2 data, 3 writeback |
| inj_dst | input | NUM_STOPS x IDW | Destination stop (ignored for kind 0) |
| inj_data | input | NUM_STOPS x DATA_W | Line address or data payload |
| out_valid | output | NUM_STOPS | Per-stop delivered message present |
| out_ready | input | NUM_STOPS | Per-stop consumer accepts delivery |
| out_src | output | NUM_STOPS x IDW | Source stop of delivered message |
| out_kind | output | NUM_STOPS x 2 | Kind of delivered message |
| out_data | output | NUM_STOPS x DATA_W | Payload of delivered message |

## Verification
A slot register that drops or corrupts a passing message shows up as a missing or altered delivery at the destination, or as a latency that differs from the hop count, within at most N cycles of injection. A delivery machine stuck in EJ_HOLD, or one that leaves it early, shows up within a cycle as out_valid or payload changing while out_ready is low. A lost recirculating message shows up as no second arrival N edges after the first pass. A wrong arbitration choice shows up at once as a request delivered in the cycle where a response was due, or as inj_ready being high while through-traffic occupies the slot.

// File: rtl/ring_pkg.sv
package ring_pkg;
    typedef enum logic [1:0] {
        MSG_RD   = 2'd0,
        MSG_SNP  = 2'd1,
        MSG_DATA = 2'd2,
        MSG_WB   = 2'd3
    } msg_kind_e;

    typedef enum logic {
        EJ_IDLE = 1'b0,
        EJ_HOLD = 1'b1
    } ej_state_e;
endpackage

// File: rtl/ring_slot.sv
// One outgoing ring register: through-traffic first, then local load.
module ring_slot
    import ring_pkg::*;
#(
    parameter int IDW    = 3,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_vld,
    input  logic [IDW-1:0] up_src,
    input  logic [IDW-1:0] up_dst,
    input  msg_kind_e up_kind,
    input  logic [DATA_W-1:0] up_data,
    input  logic take,
    input  logic load,
    input  logic [IDW-1:0] ld_src,
    input  logic [IDW-1:0] ld_dst,
    input  msg_kind_e ld_kind,
    input  logic [DATA_W-1:0] ld_data,
    output logic q_vld,
    output logic [IDW-1:0] q_src,
    output logic [IDW-1:0] q_dst,
    output msg_kind_e q_kind,
    output logic [DATA_W-1:0] q_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_src  <= '0;
            q_dst  <= '0;
            q_kind <= MSG_RD;
            q_data <= '0;
        end else if (up_vld && !take) begin
            q_vld  <= 1'b1;
            q_src  <= up_src;
            q_dst  <= up_dst;
            q_kind <= up_kind;
            q_data <= up_data;
        end else if (load) begin
            q_vld  <= 1'b1;
            q_src  <= ld_src;
            q_dst  <= ld_dst;
            q_kind <= ld_kind;
            q_data <= ld_data;
        end else begin
            q_vld  <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_eject.sv
// Delivery machine of one stop: takes at most one message per cycle.
module ring_eject
    import ring_pkg::*;
#(
    parameter int IDW     = 3,
    parameter int DATA_W  = 16,
    parameter int STOP_ID = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rq_vld,
    input  logic [IDW-1:0] rq_src,
    input  logic [IDW-1:0] rq_dst,
    input  msg_kind_e rq_kind,
    input  logic [DATA_W-1:0] rq_data,
    input  logic rs_vld,
    input  logic [IDW-1:0] rs_src,
    input  logic [IDW-1:0] rs_dst,
    input  msg_kind_e rs_kind,
    input  logic [DATA_W-1:0] rs_data,
    output logic take_rq,
    output logic take_rs,
    input  logic out_ready,
    output logic out_valid,
    output logic [IDW-1:0] out_src,
    output logic [1:0] out_kind,
    output logic [DATA_W-1:0] out_data
);
    ej_state_e state, state_nx;
    logic [IDW-1:0] h_src;
    msg_kind_e h_kind;
    logic [DATA_W-1:0] h_data;
    logic can_take, hit_rq, hit_rs;

    always_comb begin
        can_take = (state == EJ_IDLE) || out_ready;
        hit_rs   = rs_vld && (rs_dst == IDW'(STOP_ID));
        hit_rq   = rq_vld && (rq_dst == IDW'(STOP_ID));
        take_rs  = can_take && hit_rs;
        take_rq  = can_take && hit_rq && !hit_rs;
        state_nx = state;
        unique case (state)
            EJ_IDLE: if (take_rs || take_rq) state_nx = EJ_HOLD;
            EJ_HOLD: if (out_ready && !(take_rs || take_rq)) state_nx = EJ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= EJ_IDLE;
            h_src  <= '0;
            h_kind <= MSG_RD;
            h_data <= '0;
        end else begin
            state <= state_nx;
            if (take_rs) begin
                h_src  <= rs_src;
                h_kind <= rs_kind;
                h_data <= rs_data;
            end else if (take_rq) begin
                h_src  <= rq_src;
                h_kind <= rq_kind;
                h_data <= rq_data;
            end
        end
    end

    always_comb begin
        out_valid = (state == EJ_HOLD);
        out_src   = h_src;
        out_kind  = h_kind;
        out_data  = h_data;
    end
endmodule

// File: rtl/ring_stop.sv
// One stop: destination decode, injection steering, two slots, delivery.
module ring_stop
    import ring_pkg::*;
#(
    parameter int STOP_ID     = 0,
    parameter int NUM_SLICES  = 4,
    parameter int SLICE_FIRST = 1,
    parameter int LINE_OFF    = 6,
    parameter int IDW         = 3,
    parameter int DATA_W      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rq_up_vld,
    input  logic [IDW-1:0] rq_up_src,
    input  logic [IDW-1:0] rq_up_dst,
    input  msg_kind_e rq_up_kind,
    input  logic [DATA_W-1:0] rq_up_data,
    input  logic rs_up_vld,
    input  logic [IDW-1:0] rs_up_src,
    input  logic [IDW-1:0] rs_up_dst,
    input  msg_kind_e rs_up_kind,
    input  logic [DATA_W-1:0] rs_up_data,
    output logic rq_vld,
    output logic [IDW-1:0] rq_src,
    output logic [IDW-1:0] rq_dst,
    output msg_kind_e rq_kind,
    output logic [DATA_W-1:0] rq_data,
    output logic rs_vld,
    output logic [IDW-1:0] rs_src,
    output logic [IDW-1:0] rs_dst,
    output msg_kind_e rs_kind,
    output logic [DATA_W-1:0] rs_data,
    input  logic inj_valid,
    output logic inj_ready,
    input  logic [1:0] inj_kind,
    input  logic [IDW-1:0] inj_dst,
    input  logic [DATA_W-1:0] inj_data,
    input  logic out_ready,
    output logic out_valid,
    output logic [IDW-1:0] out_src,
    output logic [1:0] out_kind,
    output logic [DATA_W-1:0] out_data
);
    localparam int SIDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

    function automatic logic [SIDX_W-1:0] slice_of(input logic [DATA_W-1:0] a);
        logic [SIDX_W-1:0] f;
        f = '0;
        for (int b = LINE_OFF; b < DATA_W; b++) begin
            f[(b - LINE_OFF) % SIDX_W] ^= a[b];
        end
        return SIDX_W'(int'(f) % NUM_SLICES);
    endfunction

    msg_kind_e kind;
    logic [IDW-1:0] dst_eff;
    logic to_rs, rq_free, rs_free, fire, take_rq, take_rs;

    always_comb begin
        kind      = msg_kind_e'(inj_kind);
        dst_eff   = (kind == MSG_RD) ? IDW'(SLICE_FIRST) + IDW'(slice_of(inj_data))
                                     : inj_dst;
        to_rs     = (kind == MSG_DATA) || (kind == MSG_WB);
        rq_free   = !rq_up_vld || take_rq;
        rs_free   = !rs_up_vld || take_rs;
        inj_ready = to_rs ? rs_free : rq_free;
        fire      = inj_valid && inj_ready;
    end

    ring_slot #(.IDW(IDW), .DATA_W(DATA_W)) u_rq_slot (
        .clk, .rst_n,
        .up_vld(rq_up_vld), .up_src(rq_up_src), .up_dst(rq_up_dst),
        .up_kind(rq_up_kind), .up_data(rq_up_data),
        .take(take_rq), .load(fire && !to_rs),
        .ld_src(IDW'(STOP_ID)), .ld_dst(dst_eff), .ld_kind(kind), .ld_data(inj_data),
        .q_vld(rq_vld), .q_src(rq_src), .q_dst(rq_dst), .q_kind(rq_kind), .q_data(rq_data)
    );

    ring_slot #(.IDW(IDW), .DATA_W(DATA_W)) u_rs_slot (
        .clk, .rst_n,
        .up_vld(rs_up_vld), .up_src(rs_up_src), .up_dst(rs_up_dst),
        .up_kind(rs_up_kind), .up_data(rs_up_data),
        .take(take_rs), .load(fire && to_rs),
        .ld_src(IDW'(STOP_ID)), .ld_dst(dst_eff), .ld_kind(kind), .ld_data(inj_data),
        .q_vld(rs_vld), .q_src(rs_src), .q_dst(rs_dst), .q_kind(rs_kind), .q_data(rs_data)
    );

    ring_eject #(.IDW(IDW), .DATA_W(DATA_W), .STOP_ID(STOP_ID)) u_eject (
        .clk, .rst_n,
        .rq_vld(rq_up_vld), .rq_src(rq_up_src), .rq_dst(rq_up_dst),
        .rq_kind(rq_up_kind), .rq_data(rq_up_data),
        .rs_vld(rs_up_vld), .rs_src(rs_up_src), .rs_dst(rs_up_dst),
        .rs_kind(rs_up_kind), .rs_data(rs_up_data),
        .take_rq, .take_rs,
        .out_ready, .out_valid, .out_src, .out_kind, .out_data
    );
endmodule

// File: rtl/ring_fabric.sv
// Ring of stops: requests move up in stop number, responses move down.
module ring_fabric
    import ring_pkg::*;
#(
    parameter int NUM_STOPS   = 6,
    parameter int NUM_SLICES  = 4,
    parameter int SLICE_FIRST = 1,
    parameter int LINE_OFF    = 6,
    parameter int DATA_W      = 16,
    localparam int IDW        = (NUM_STOPS > 1) ? $clog2(NUM_STOPS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [NUM_STOPS-1:0] inj_valid,
    output logic [NUM_STOPS-1:0] inj_ready,
    input  logic [NUM_STOPS-1:0][1:0] inj_kind,
    input  logic [NUM_STOPS-1:0][IDW-1:0] inj_dst,
    input  logic [NUM_STOPS-1:0][DATA_W-1:0] inj_data,
    output logic [NUM_STOPS-1:0] out_valid,
    input  logic [NUM_STOPS-1:0] out_ready,
    output logic [NUM_STOPS-1:0][IDW-1:0] out_src,
    output logic [NUM_STOPS-1:0][1:0] out_kind,
    output logic [NUM_STOPS-1:0][DATA_W-1:0] out_data
);
    logic              rq_vld  [NUM_STOPS];
    logic [IDW-1:0]    rq_src  [NUM_STOPS];
    logic [IDW-1:0]    rq_dst  [NUM_STOPS];
    msg_kind_e         rq_kind [NUM_STOPS];
    logic [DATA_W-1:0] rq_data [NUM_STOPS];
    logic              rs_vld  [NUM_STOPS];
    logic [IDW-1:0]    rs_src  [NUM_STOPS];
    logic [IDW-1:0]    rs_dst  [NUM_STOPS];
    msg_kind_e         rs_kind [NUM_STOPS];
    logic [DATA_W-1:0] rs_data [NUM_STOPS];

    for (genvar i = 0; i < NUM_STOPS; i++) begin : g_stop
        localparam int PRV = (i + NUM_STOPS - 1) % NUM_STOPS;
        localparam int NXT = (i + 1) % NUM_STOPS;
        ring_stop #(
            .STOP_ID(i), .NUM_SLICES(NUM_SLICES), .SLICE_FIRST(SLICE_FIRST),
            .LINE_OFF(LINE_OFF), .IDW(IDW), .DATA_W(DATA_W)
        ) u_stop (
            .clk, .rst_n,
            .rq_up_vld(rq_vld[PRV]), .rq_up_src(rq_src[PRV]), .rq_up_dst(rq_dst[PRV]),
            .rq_up_kind(rq_kind[PRV]), .rq_up_data(rq_data[PRV]),
            .rs_up_vld(rs_vld[NXT]), .rs_up_src(rs_src[NXT]), .rs_up_dst(rs_dst[NXT]),
            .rs_up_kind(rs_kind[NXT]), .rs_up_data(rs_data[NXT]),
            .rq_vld(rq_vld[i]), .rq_src(rq_src[i]), .rq_dst(rq_dst[i]),
            .rq_kind(rq_kind[i]), .rq_data(rq_data[i]),
            .rs_vld(rs_vld[i]), .rs_src(rs_src[i]), .rs_dst(rs_dst[i]),
            .rs_kind(rs_kind[i]), .rs_data(rs_data[i]),
            .inj_valid(inj_valid[i]), .inj_ready(inj_ready[i]), .inj_kind(inj_kind[i]),
            .inj_dst(inj_dst[i]), .inj_data(inj_data[i]),
            .out_ready(out_ready[i]), .out_valid(out_valid[i]), .out_src(out_src[i]),
            .out_kind(out_kind[i]), .out_data(out_data[i])
        );
    end
endmodule

// File: rtl/ring_fabric_chk.sv
module ring_fabric_chk
    import ring_pkg::*;
#(
    parameter int NUM_STOPS = 6,
    parameter int IDW       = 3,
    parameter int DATA_W    = 16
) (
    input logic clk,
    input logic rst_n,
    input logic [NUM_STOPS-1:0] inj_valid,
    input logic [NUM_STOPS-1:0] inj_ready,
    input logic [NUM_STOPS-1:0][1:0] inj_kind,
    input logic [NUM_STOPS-1:0] out_valid,
    input logic [NUM_STOPS-1:0] out_ready,
    input logic [NUM_STOPS-1:0][IDW-1:0] out_src,
    input logic [NUM_STOPS-1:0][1:0] out_kind,
    input logic [NUM_STOPS-1:0][DATA_W-1:0] out_data,
    input logic              rq_vld  [NUM_STOPS],
    input logic [IDW-1:0]    rq_src  [NUM_STOPS],
    input logic [IDW-1:0]    rq_dst  [NUM_STOPS],
    input msg_kind_e         rq_kind [NUM_STOPS],
    input logic [DATA_W-1:0] rq_data [NUM_STOPS],
    input logic              rs_vld  [NUM_STOPS],
    input logic [IDW-1:0]    rs_src  [NUM_STOPS],
    input logic [IDW-1:0]    rs_dst  [NUM_STOPS],
    input msg_kind_e         rs_kind [NUM_STOPS],
    input logic [DATA_W-1:0] rs_data [NUM_STOPS]
);
    for (genvar i = 0; i < NUM_STOPS; i++) begin : g_chk
        localparam int PRV = (i + NUM_STOPS - 1) % NUM_STOPS;
        localparam int NXT = (i + 1) % NUM_STOPS;

        // R6
        hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[i] && !out_ready[i] |=> out_valid[i] && $stable(out_src[i])
                && $stable(out_kind[i]) && $stable(out_data[i]));

        // R2
        rq_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rq_vld[i] && rq_dst[i] != IDW'(NXT) |=> rq_vld[NXT]
                && rq_src[NXT] == $past(rq_src[i]) && rq_kind[NXT] == $past(rq_kind[i])
                && rq_data[NXT] == $past(rq_data[i]));

        // R2
        rs_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rs_vld[i] && rs_dst[i] != IDW'(PRV) |=> rs_vld[PRV]
                && rs_src[PRV] == $past(rs_src[i]) && rs_kind[PRV] == $past(rs_kind[i])
                && rs_data[PRV] == $past(rs_data[i]));

        // R5
        inj_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            inj_valid[i] && inj_ready[i] && (inj_kind[i] == MSG_RD || inj_kind[i] == MSG_SNP)
                |=> rq_vld[i] && rq_src[i] == IDW'(i));

        // R6
        recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rq_vld[PRV] && rq_dst[PRV] == IDW'(i) && out_valid[i] && !out_ready[i]
                |=> rq_vld[i] && rq_dst[i] == IDW'(i));

        // R7
        rsp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rs_vld[NXT] && rs_dst[NXT] == IDW'(i) && (!out_valid[i] || out_ready[i])
                |=> out_valid[i] && (out_kind[i] == MSG_DATA || out_kind[i] == MSG_WB));
    end
endmodule

bind ring_fabric ring_fabric_chk #(.NUM_STOPS(NUM_STOPS), .IDW(IDW), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_ready(inj_ready),
    .inj_kind(inj_kind), .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_kind(out_kind), .out_data(out_data),
    .rq_vld(rq_vld), .rq_src(rq_src), .rq_dst(rq_dst), .rq_kind(rq_kind), .rq_data(rq_data),
    .rs_vld(rs_vld), .rs_src(rs_src), .rs_dst(rs_dst), .rs_kind(rs_kind), .rs_data(rs_data)
);

// File: tb/test_ring_fabric.sv
module test_ring_fabric;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 6;
    localparam int IDW = 3;
    localparam int DW  = 16;
    localparam int VN  = 12;

    // stimulus: source, kind, given destination, data; expected stop and edges
    localparam int V_SRC [VN] = '{0, 4, 2, 1, 5, 0, 3, 2, 3, 0, 1, 3};
    localparam int V_KIND[VN] = '{1, 1, 2, 3, 0, 0, 0, 0, 1, 2, 1, 2};
    localparam int V_DST [VN] = '{3, 1, 1, 5, 0, 5, 0, 2, 3, 0, 0, 0};
    localparam int V_DATA[VN] = '{'h1111, 'h2222, 'h3333, 'h4444, 'h0040, 'h00C0,
                                  'h0F00, 'hFFC0, 'h5555, 'h6666, 'h7777, 'h8888};
    localparam int E_STOP[VN] = '{3, 1, 1, 5, 2, 4, 1, 4, 3, 0, 0, 0};
    localparam int E_LAT [VN] = '{3, 3, 1, 2, 3, 4, 4, 2, 6, 6, 5, 3};

    logic clk = 0;
    logic rst_n = 0;
    logic [NS-1:0] inj_valid = '0;
    logic [NS-1:0] inj_ready;
    logic [NS-1:0][1:0] inj_kind = '0;
    logic [NS-1:0][IDW-1:0] inj_dst = '0;
    logic [NS-1:0][DW-1:0] inj_data = '0;
    logic [NS-1:0] out_valid;
    logic [NS-1:0] out_ready = '1;
    logic [NS-1:0][IDW-1:0] out_src;
    logic [NS-1:0][1:0] out_kind;
    logic [NS-1:0][DW-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_fabric #(.NUM_STOPS(NS), .NUM_SLICES(4), .SLICE_FIRST(1), .LINE_OFF(6),
                  .DATA_W(DW)) i_ring_fabric (
        .clk, .rst_n, .inj_valid, .inj_ready, .inj_kind, .inj_dst, .inj_data,
        .out_valid, .out_ready, .out_src, .out_kind, .out_data
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int s, input int k, input int d, input int a,
                           input int es, input int el);
        string tg;
        int lat;
        bit found;
        tg = (k == 0) ? "R4" : ((s == es) ? "R3" : "R2");
        @(negedge clk);
        inj_valid[s] = 1'b1;
        inj_kind[s]  = 2'(k);
        inj_dst[s]   = IDW'(d);
        inj_data[s]  = DW'(a);
        #1 chk(inj_ready[s] == 1'b1, "R5", "ready on idle ring", int'(inj_ready[s]), 1);
        @(posedge clk);
        @(negedge clk);
        inj_valid[s] = 1'b0;
        lat = 0;
        found = 0;
        while (!found && lat < 20) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (|out_valid) found = 1;
        end
        chk(lat == el, tg, "latency", lat, el);
        chk(out_valid == (NS'(1) << es), tg, "delivery stop", int'(out_valid), 1 << es);
        chk(out_src[es] == IDW'(s) && out_kind[es] == 2'(k) && out_data[es] == DW'(a),
            "R8", "payload", int'(out_data[es]), a);
    endtask

    initial begin
        int t3, t4, td, te;
        bit gap_bad;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == '0, "R1", "outputs during reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R1", "outputs after reset", int'(out_valid), 0);
        chk(inj_ready == '1, "R1", "ready after reset", int'(inj_ready), 6'h3F);

        for (int v = 0; v < VN; v++) begin
            run_vec(V_SRC[v], V_KIND[v], V_DST[v], V_DATA[v], E_STOP[v], E_LAT[v]);
        end

        // R5: through-traffic at stop 1 blocks its request-ring injection
        @(negedge clk);
        inj_valid[0] = 1; inj_kind[0] = 2'd1; inj_dst[0] = 3'd3; inj_data[0] = 16'hA1A1;
        @(posedge clk);
        @(negedge clk);
        inj_valid[0] = 0;
        inj_valid[1] = 1; inj_kind[1] = 2'd2; inj_dst[1] = 3'd4; inj_data[1] = 16'hB2B2;
        #1 chk(inj_ready[1] == 1'b1, "R5", "response ring free", int'(inj_ready[1]), 1);
        inj_kind[1] = 2'd1;
        #1 chk(inj_ready[1] == 1'b0, "R5", "blocked by through traffic", int'(inj_ready[1]), 0);
        t3 = -1; t4 = -1;
        for (int e = 1; e <= 10; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == 1) chk(inj_ready[1] == 1'b1, "R5", "ready next cycle", int'(inj_ready[1]), 1);
            if (e == 2) inj_valid[1] = 0;
            if (out_valid[3] && t3 < 0) t3 = e;
            if (out_valid[4] && t4 < 0) t4 = e;
        end
        chk(t3 == 3, "R5", "through traffic latency", t3, 3);
        chk(t4 == 5, "R5", "deferred injection arrival", t4, 5);

        // R6: backpressure at stop 3, second message recirculates
        out_ready[3] = 0;
        @(negedge clk);
        inj_valid[0] = 1; inj_kind[0] = 2'd1; inj_dst[0] = 3'd3; inj_data[0] = 16'hC3C3;
        @(posedge clk);
        @(negedge clk);
        inj_data[0] = 16'hD4D4;
        td = -1; gap_bad = 0;
        for (int e = 1; e <= 14; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == 1) inj_valid[0] = 0;
            if (e == 3) chk(out_valid[3] && out_data[3] == 16'hC3C3, "R6", "first arrival",
                            int'(out_data[3]), 'hC3C3);
            if (e == 6) begin
                chk(out_valid[3] && out_data[3] == 16'hC3C3, "R6", "held under backpressure",
                    int'(out_data[3]), 'hC3C3);
                out_ready[3] = 1;
            end
            if (e >= 7 && e <= 9 && out_valid[3]) gap_bad = 1;
            if (out_valid[3] && out_data[3] == 16'hD4D4 && td < 0) td = e;
        end
        chk(!gap_bad, "R6", "idle while second circulates", int'(gap_bad), 0);
        chk(td == 10, "R6", "recirculated delivery edge", td, 10);

        // R7: request and response reach stop 3 together
        @(negedge clk);
        inj_valid[2] = 1; inj_kind[2] = 2'd1; inj_dst[2] = 3'd3; inj_data[2] = 16'hE5E5;
        inj_valid[4] = 1; inj_kind[4] = 2'd2; inj_dst[4] = 3'd3; inj_data[4] = 16'hF6F6;
        @(posedge clk);
        @(negedge clk);
        inj_valid[2] = 0; inj_valid[4] = 0;
        te = -1; gap_bad = 0;
        for (int e = 1; e <= 10; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == 1) chk(out_valid[3] && out_kind[3] == 2'd2 && out_src[3] == 3'd4
                            && out_data[3] == 16'hF6F6, "R7", "response delivered first",
                            int'(out_data[3]), 'hF6F6);
            if (e >= 2 && e <= 6 && out_valid[3]) gap_bad = 1;
            if (out_valid[3] && out_data[3] == 16'hE5E5 && te < 0) te = e;
        end
        chk(!gap_bad, "R7", "request still circulating", int'(gap_bad), 0);
        chk(te == 7, "R7", "request delivered after lap", te, 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule